// File: doc/BRIEF.md
# Byte-Programmed Watchdog with Reset/Interrupt Steering

This block is a watchdog timer that software arms with a single configuration byte. The byte holds a two-bit resolution code, a five-bit multiplier and a steering bit. The timeout is counted in ticks of an external 16 Hz strobe, so the four resolution codes give steps of 1/16 s, 1/4 s, 1 s and 4 s. Each write of the byte stores it and restarts the countdown. Each read strobe of the byte restarts the countdown from the stored value. A stored value of zero leaves the watchdog idle.

When the countdown runs out, a sticky expiry flag is raised. The flag appears as the top bit of a read-only flags byte. The steering bit then selects the response:
- **Steering bit set:** a one-cycle system reset request is issued. The configuration byte is wiped to zero, and a companion century bit, held in the block on behalf of the calendar logic, is cleared.
- **Steering bit clear:** a one-cycle interrupt pulse is issued, and the configuration byte is kept.

After expiry the counter stays stopped until the next restart. The 16 Hz tick source and the reset controller lie outside the block.

Top module: `wdog_steer_top`

## Requirements
- R1: The timeout in ticks is 4^res × mult, where res is configuration bits [1:0] and mult is bits [6:2]. Expiry takes effect on the tick that completes the count. A nonzero byte with mult = 0 expires on the first tick after the restart.
- R2: A write strobe stores the byte so that it reads back on `cfg_rdata`, and restarts the countdown. A stored value of 0x00 never expires.
- R3: A read strobe restarts the countdown from the stored byte and leaves the byte unchanged.
- R4: Every restart clears the expiry flag. The flag is bit 7 of `flags_rdata`, and bits 6:0 always read zero. Expiry sets the flag, which stays set until the next restart.
- R5: Expiry with bit 7 of the stored byte set has three effects: `rst_req` goes high for exactly one cycle, `cfg_rdata` becomes 0x00, and `cent_bit` becomes 0. This clearing wins over a `cent_wr` in the same cycle.
- R6: Expiry with bit 7 of the stored byte clear gives a one-cycle pulse on `irq` and leaves the stored byte unchanged.
- R7: Writes through `flags_wr`/`flags_wdata` have no effect on any output.
- R8: After expiry no further expiry occurs until a restart, whatever the ticks.
- R9: A restart in the same cycle as a tick that would complete the count wins: no expiry occurs, and counting begins afresh.
- R10: After reset, `cfg_rdata`, `flags_rdata`, `cent_bit`, `rst_req` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16 Hz |
| cfg_wr | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to store |
| cfg_rd | input | 1 | Read strobe for the configuration byte (restarts the countdown) |
| cfg_rdata | output | 8 | Stored configuration byte |
| flags_wr | input | 1 | Write strobe to the flags byte (ignored) |
| flags_wdata | input | 8 | Data for the flags byte (ignored) |
| flags_rdata | output | 8 | Flags byte, expiry flag in bit 7 |
| cent_wr | input | 1 | Write strobe for the century bit |
| cent_wdata | input | 1 | Century bit value to store |
| cent_bit | output | 1 | Stored century bit |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its defaults: a two-bit resolution code and a five-bit multiplier in an eight-bit byte. This puts all four resolution steps within reach, along with the multiplier extremes of 0 and 31. The longest timeout, 1984 ticks, is run in full. Random bytes are biased toward short timeouts, so that expiry, restart collisions and both steering outcomes recur many times. A cycle model in the bench tracks the stored byte, flag, century bit and pulses on every cycle.

// File: rtl/wdog_pkg.sv
// Shared types for the steered watchdog.
// Assumes: one expiry event per cycle at most.
package wdog_pkg;

    // Expiry event handed from the counter path to the response logic.
    typedef struct packed {
        logic fire;      // countdown completed this cycle
        logic to_reset;  // steering bit chose the reset response
    } wdog_evt_t;

    // Origin of a restart in a given cycle.
    typedef enum logic [1:0] {
        RS_NONE  = 2'd0,
        RS_WRITE = 2'd1,
        RS_READ  = 2'd2
    } wdog_restart_t;

endpackage

// File: rtl/wdog_decode.sv
// Turns a configuration byte into a tick count: 4^res * mult.
// Assumes: res sits in the low RES_W bits, mult directly above it.
module wdog_decode #(
    parameter int RES_W = 2,
    parameter int MUL_W = 5,
    parameter int REG_W = 8
) (
    input  logic [REG_W-1:0] cfg,
    output logic [MUL_W + 2*((1<<RES_W)-1) - 1:0] load_val,
    output logic             nonzero
);
    localparam int NRES  = 1 << RES_W;
    localparam int CNT_W = MUL_W + 2*(NRES-1);

    logic [RES_W-1:0] res;
    logic [MUL_W-1:0] mult;
    logic [CNT_W-1:0] opt [NRES];

    // Split the byte into its fields.
    assign res     = cfg[RES_W-1:0];
    assign mult    = cfg[RES_W+MUL_W-1:RES_W];
    assign nonzero = |cfg;

    // One pre-shifted candidate per resolution code.
    for (genvar r = 0; r < NRES; r++) begin : g_res
        assign opt[r] = CNT_W'(mult) << (2*r);
    end

    // Pick the candidate for the current resolution code.
    always_comb begin
        load_val = opt[res];
    end

endmodule

// File: rtl/wdog_cfg.sv
// Holds the configuration byte and the century bit.
// Assumes: a write and a steered clear never meet (the counter gives restarts priority).
module wdog_cfg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             wipe,
    input  logic             cent_wr,
    input  logic             cent_wdata,
    output logic [REG_W-1:0] cfg_q,
    output logic             cent_q
);

    // Configuration byte: written by software, wiped on a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr)    cfg_q <= wdata;
        else if (wipe)  cfg_q <= '0;
    end

    // Century bit: the wipe wins over a same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n)       cent_q <= 1'b0;
        else if (wipe)    cent_q <= 1'b0;
        else if (cent_wr) cent_q <= cent_wdata;
    end

endmodule

// File: rtl/wdog_count.sv
// Down-counter in 16 Hz ticks; flags completion and then idles.
// Assumes: tick is a one-cycle strobe; a restart has priority over expiry.
module wdog_count #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             arm,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire,
    output logic             active
);
    logic [CNT_W-1:0] cnt;

    // Completion: armed, ticking, one or fewer ticks left, no restart.
    assign expire = active && tick && !restart && (cnt <= CNT_W'(1));

    // Load on restart, stop on completion, otherwise count ticks down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (restart) begin
            active <= arm;
            cnt    <= load_val;
        end else if (expire) begin
            active <= 1'b0;
        end else if (tick && active) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdog_resp.sv
// Sticky expiry flag and the steered one-cycle responses.
// Assumes: restart and expiry are never both high.
module wdog_resp
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  wdog_evt_t evt,
    output logic      flag,
    output logic      rst_req,
    output logic      irq
);

    // Expiry flag: cleared by each restart, set by expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (restart)  flag <= 1'b0;
        else if (evt.fire) flag <= 1'b1;
    end

    // Steered pulses, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= evt.fire && evt.to_reset;
            irq     <= evt.fire && !evt.to_reset;
        end
    end

endmodule

// File: rtl/wdog_steer_top.sv
// Byte-programmed watchdog: decode, count, respond, steer.
// Assumes: strobes are synchronous one-cycle pulses; tick16 comes from outside.
module wdog_steer_top
    import wdog_pkg::*;
#(
    parameter int RES_W = 2,
    parameter int MUL_W = 5,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             cfg_rd,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             flags_wr,
    input  logic [REG_W-1:0] flags_wdata,
    output logic [REG_W-1:0] flags_rdata,
    input  logic             cent_wr,
    input  logic             cent_wdata,
    output logic             cent_bit,
    output logic             rst_req,
    output logic             irq
);
    localparam int NRES  = 1 << RES_W;
    localparam int CNT_W = MUL_W + 2*(NRES-1);

    wdog_restart_t    rs_src;
    logic             restart;
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] load_byte;
    logic [CNT_W-1:0] load_val;
    logic             arm;
    logic             expire;
    logic             active;
    logic             flag;
    wdog_evt_t        evt;
    logic             unused_flags_port;

    // The flags byte is read-only; its write port is deliberately dropped.
    assign unused_flags_port = ^{flags_wr, flags_wdata, active};

    // Classify this cycle's restart; a write takes precedence over a read.
    always_comb begin
        if (cfg_wr)      rs_src = RS_WRITE;
        else if (cfg_rd) rs_src = RS_READ;
        else             rs_src = RS_NONE;
    end
    assign restart   = (rs_src != RS_NONE);
    assign load_byte = (rs_src == RS_WRITE) ? cfg_wdata : cfg_q;

    // Build the expiry event with the steering bit of the stored byte.
    assign evt.fire     = expire;
    assign evt.to_reset = cfg_q[REG_W-1];

    wdog_cfg #(.REG_W(REG_W)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .wdata(cfg_wdata),
        .wipe(evt.fire && evt.to_reset),
        .cent_wr(cent_wr), .cent_wdata(cent_wdata),
        .cfg_q(cfg_q), .cent_q(cent_bit)
    );

    wdog_decode #(.RES_W(RES_W), .MUL_W(MUL_W), .REG_W(REG_W)) dec_i (
        .cfg(load_byte), .load_val(load_val), .nonzero(arm)
    );

    wdog_count #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .restart(restart), .arm(arm), .load_val(load_val),
        .expire(expire), .active(active)
    );

    wdog_resp resp_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .evt(evt),
        .flag(flag), .rst_req(rst_req), .irq(irq)
    );

    // Present the stored byte and the flags byte.
    assign cfg_rdata   = cfg_q;
    assign flags_rdata = {flag, {(REG_W-1){1'b0}}};

endmodule

// File: rtl/wdog_steer_chk.sv
// Temporal checks on the watchdog ports; attached by bind.
module wdog_steer_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_rd,
    input logic [REG_W-1:0] cfg_rdata,
    input logic [REG_W-1:0] flags_rdata,
    input logic             cent_bit,
    input logic             rst_req,
    input logic             irq
);
    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq));
    // R5
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R5
    rst_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cfg_rdata == '0 && !cent_bit));
    // R4
    flag_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || irq) |-> flags_rdata[REG_W-1]);
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_rdata[REG_W-1]) |-> (rst_req || irq));
    // R4
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_rdata[REG_W-1]) |-> $past(cfg_wr || cfg_rd));
    // R7
    flags_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rdata[REG_W-2:0] == '0);
    // R2
    cfg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_rdata) |-> ($past(cfg_wr) || rst_req));
endmodule

bind wdog_steer_top wdog_steer_chk #(.REG_W(REG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_rdata(cfg_rdata), .flags_rdata(flags_rdata), .cent_bit(cent_bit),
    .rst_req(rst_req), .irq(irq)
);

// File: tb/wdog_steer_top_tb.sv
module wdog_steer_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 200000;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick16 = 0, cfg_wr = 0, cfg_rd = 0, flags_wr = 0, cent_wr = 0, cent_wdata = 0;
    logic [7:0] cfg_wdata = 0, flags_wdata = 0;
    logic [7:0] cfg_rdata, flags_rdata;
    logic       cent_bit, rst_req, irq;

    int total = 0, bad = 0, cycles = 0;

    // reference model state
    logic [7:0] m_cfg;
    int         m_cnt;
    bit         m_act, m_flag, m_rst, m_irq, m_cent;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_steer_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
        .flags_wr(flags_wr), .flags_wdata(flags_wdata), .flags_rdata(flags_rdata),
        .cent_wr(cent_wr), .cent_wdata(cent_wdata), .cent_bit(cent_bit),
        .rst_req(rst_req), .irq(irq)
    );

    // R1: ticks for a byte = 4^res * mult
    function automatic int exp_ticks(logic [7:0] v);
        return (1 << (2 * int'(v[1:0]))) * int'(v[6:2]);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic m_load(logic [7:0] v);
        m_flag = 0;
        m_act  = (v != 0);
        m_cnt  = exp_ticks(v);
    endtask

    // Advance the model by one clock using the current inputs.
    task automatic m_step();
        bit fire;
        m_rst = 0; m_irq = 0; fire = 0;
        if (!rst_n) begin
            m_cfg = 0; m_cnt = 0; m_act = 0; m_flag = 0; m_cent = 0;
            return;
        end
        if (cfg_wr) begin
            m_cfg = cfg_wdata; m_load(cfg_wdata);
        end else if (cfg_rd) begin
            m_load(m_cfg);
        end else if (tick16 && m_act && m_cnt <= 1) begin
            fire = 1; m_act = 0; m_flag = 1;
            if (m_cfg[7]) begin m_rst = 1; m_cfg = 0; end
            else m_irq = 1;
        end else if (tick16 && m_act) begin
            m_cnt--;
        end
        if (fire && m_rst) m_cent = 0;
        else if (cent_wr) m_cent = cent_wdata;
    endtask

    // One clock: model update after the edge, compare away from the edge.
    task automatic step();
        @(posedge clk);
        m_step();
        cycles++;
        @(negedge clk);
        check("R2 cfg_rdata", cfg_rdata, m_cfg);
        check("R4 flags_rdata", flags_rdata, {m_flag, 7'b0});
        check("R5 cent_bit", cent_bit, m_cent);
        check("R5 rst_req", rst_req, m_rst);
        check("R6 irq", irq, m_irq);
    endtask

    task automatic idle();
        tick16 = 0; cfg_wr = 0; cfg_rd = 0; flags_wr = 0; cent_wr = 0;
    endtask

    task automatic wr_cfg(logic [7:0] v);
        cfg_wr = 1; cfg_wdata = v; step(); idle();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin tick16 = 1; step(); end
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYC);
        bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        for (int i = 0; i < 3; i++) step();
        rst_n = 1;
        // R10: reset state
        check("R10 cfg", cfg_rdata, 0);
        check("R10 flags", flags_rdata, 0);
        check("R10 pulses", {rst_req, irq, cent_bit}, 0);

        // R1/R6: res=1 mult=3 -> 12 ticks, interrupt steering
        wr_cfg(8'h0D);
        ticks(11);
        check("R1 no early irq", irq, 0);
        ticks(1);
        check("R1 irq on 12th tick", irq, 1);
        check("R6 cfg kept", cfg_rdata, 8'h0D);
        // R8: stopped after expiry
        ticks(30);
        check("R8 no re-fire", irq, 0);
        // R7: flags write ignored
        flags_wr = 1; flags_wdata = 8'h00; step(); idle();
        check("R7 flag kept", flags_rdata, 8'h80);
        // R3: read restarts and clears flag
        cfg_rd = 1; step(); idle();
        check("R3 flag cleared", flags_rdata, 0);
        ticks(12);
        check("R3 re-expiry", irq, 1);

        // R5: reset steering, res=0 mult=2
        cent_wr = 1; cent_wdata = 1; step(); idle();
        wr_cfg(8'h88);
        ticks(2);
        check("R5 rst_req", rst_req, 1);
        check("R5 cfg wiped", cfg_rdata, 0);
        check("R5 cent cleared", cent_bit, 0);
        step();
        check("R5 rst single", rst_req, 0);

        // R5: wipe beats same-cycle century write
        wr_cfg(8'h84);
        tick16 = 1; cent_wr = 1; cent_wdata = 1; step(); idle();
        check("R5 cent priority", cent_bit, 0);

        // R9: restart collides with completing tick
        wr_cfg(8'h05);
        ticks(3);
        tick16 = 1; cfg_rd = 1; step(); idle();
        check("R9 no expiry on collision", irq, 0);
        ticks(3);
        check("R9 still counting", irq, 0);
        ticks(1);
        check("R9 expiry after fresh count", irq, 1);

        // R2: zero disables
        wr_cfg(8'h00);
        ticks(100);
        check("R2 zero never fires", flags_rdata, 0);

        // R1: nonzero with mult 0 fires on first tick
        wr_cfg(8'h03);
        ticks(1);
        check("R1 mult0 fires", irq, 1);

        // R1: longest timeout, 1984 ticks
        wr_cfg(8'h7F);
        ticks(1983);
        check("R1 max no early", flags_rdata, 0);
        ticks(1);
        check("R1 max fires", irq, 1);

        // Random phase, biased to short timeouts
        for (int i = 0; i < 8000; i++) begin
            logic [7:0] v;
            tick16 = ($urandom % 2) == 0;
            cfg_wr = ($urandom % 30) == 0;
            cfg_rd = !cfg_wr && (($urandom % 40) == 0);
            v = 8'($urandom);
            v[1:0] = ($urandom % 4 == 0) ? 2'($urandom % 3) : 2'd0;
            if (v[1:0] != 0) v[6:2] = 5'($urandom % 4);
            cfg_wdata = v;
            flags_wr = ($urandom % 8) == 0;
            flags_wdata = 8'($urandom);
            cent_wr = ($urandom % 16) == 0;
            cent_wdata = 1'($urandom);
            step();
        end
        idle();
        step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule